// File: doc/BRIEF.md
# Keyed Power-Down Controller with Wake Detection

This block sits in the always-on domain on a slow clock. It owns the power-enable output for the main supply. Software turns the supply off by writing a command to the control word. The write must carry an 8-bit password in its upper byte. A write with the wrong password changes nothing.

While the supply is off, the block watches three wake sources and restores power as soon as an enabled one qualifies. The first source is an external wake pin. It passes through a synchronizer, then a programmable level test (high, low, or a change from the level seen at power-down), then a debounce counter. The other two sources are single-cycle pulses, one from a real-time timer and one from a real-time clock.

Each wake latches its cause into a status word. That word clears when it is read, so after boot software can tell why the system came back. Software reaches all three words over a simple single-cycle 32-bit register bus with byte offsets 0x0, 0x4 and 0x8.

Top module: `sdc_top`

## Requirements
- R1: After reset, `pwr_en` is 1, the configuration word reads 0 and the status word reads 0.
- R2: A bus write to offset 0x0 that has bit 0 set and 0xA5 in bits 31:24 drives `pwr_en` low from the next clock edge. Offset 0x0 always reads 0.
- R3: The configuration word at offset 0x4 holds these fields: pin mode in bits 2:0, debounce count in bits 7:4, timer wake enable in bit 16 and clock wake enable in bit 17. It reads back exactly these fields, and every other bit reads 0.
- R4: A write to offset 0x0 with any upper byte other than 0xA5, or with bit 0 clear, leaves `pwr_en` unchanged.
- R5: The pin mode selects when the pin qualifies:
  - 1: the synchronized pin is high.
  - 2: the synchronized pin is low.
  - 3: the synchronized pin differs from the level it had when power-down was accepted.
  - 0 and 4 to 7: the pin is disabled.
- R6: The pin goes through a 2-stage synchronizer. It wakes the system only after the selected condition holds for count+1 consecutive sampled cycles. A pin change driven before clock edge 1 raises `pwr_en` at edge count+3, and a condition that holds for only `count` samples causes no wake.
- R7: While power is off, a one-cycle `tmr_wake` pulse (with bit 16 set) or `clk_wake` pulse (with bit 17 set) raises `pwr_en` at the next edge. The same edge sets status bit 16 (timer) or bit 17 (clock). A pin wake sets status bit 0.
- R8: Wake events have no effect in two cases: while `pwr_en` is high, and when their source is disabled. In both cases `pwr_en` and the status word stay as they were.
- R9: A read of offset 0x8 returns the status word and clears it at that clock edge. A wake that lands in the same cycle is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_sel` is high |
| wake_pin | input | 1 | Asynchronous wake pin |
| tmr_wake | input | 1 | Real-time timer wake pulse |
| clk_wake | input | 1 | Real-time clock wake pulse |
| pwr_en | output | 1 | Main supply enable, 1 = powered |

## Verification
Several properties are checked on every cycle:
- a keyed command always powers down, and a command with a bad key never does;
- nothing disturbs power or status while the system is powered;
- a system with every source disabled stays off;
- an enabled timer pulse always wakes the system and sets its status bit;
- a status read made while powered always empties the word.

The debounce length, the exact wake edge after synchronization, the mode-3 reference captured at power-down, and the combined status pattern from mixed sources are shown only by the bench's directed and random scenarios.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int DBC_W     = 4;
  localparam int MODE_W    = 3;
  localparam logic [7:0] SHUT_KEY = 8'hA5;
  localparam int OFS_CTRL  = 0;
  localparam int OFS_MODE  = 4;
  localparam int OFS_STAT  = 8;
  localparam int BIT_TMR   = 16;
  localparam int BIT_CLK   = 17;
  localparam int NSRC      = 3;
  localparam int SRC_PIN   = 0;
  localparam int SRC_TMR   = 1;
  localparam int SRC_CLK   = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_OFF  = 3'd0,
    PM_HIGH = 3'd1,
    PM_LOW  = 3'd2,
    PM_CHG  = 3'd3
  } pin_mode_e;

  typedef struct packed {
    logic [MODE_W-1:0] pmode;
    logic [DBC_W-1:0]  dbc;
    logic              tmr_en;
    logic              clk_en;
  } mode_cfg_t;
endpackage

// File: rtl/sdc_regs.sv
module sdc_regs
  import sdc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [NSRC-1:0]   stat,
  output logic [31:0]       bus_rdata,
  output mode_cfg_t         cfg,
  output logic              shut_req,
  output logic              stat_rd
);
  mode_cfg_t cfg_q, cfg_d;
  logic      hit_ctrl, hit_mode, hit_stat;
  logic      mode_we;

  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign mode_we  = bus_sel && bus_wr && hit_mode;
  assign shut_req = bus_sel && bus_wr && hit_ctrl &&
                    (bus_wdata[31:24] == SHUT_KEY) && bus_wdata[0];
  assign stat_rd  = bus_sel && !bus_wr && hit_stat;

  always_comb begin
    cfg_d = cfg_q;
    if (mode_we) begin
      cfg_d.pmode  = bus_wdata[MODE_W-1:0];
      cfg_d.dbc    = bus_wdata[4 +: DBC_W];
      cfg_d.tmr_en = bus_wdata[BIT_TMR];
      cfg_d.clk_en = bus_wdata[BIT_CLK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (mode_we) cfg_q <= cfg_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_mode) begin
      bus_rdata[MODE_W-1:0] = cfg_q.pmode;
      bus_rdata[4 +: DBC_W] = cfg_q.dbc;
      bus_rdata[BIT_TMR]    = cfg_q.tmr_en;
      bus_rdata[BIT_CLK]    = cfg_q.clk_en;
    end else if (hit_stat) begin
      bus_rdata[0]       = stat[SRC_PIN];
      bus_rdata[BIT_TMR] = stat[SRC_TMR];
      bus_rdata[BIT_CLK] = stat[SRC_CLK];
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/sdc_pin_qual.sv
module sdc_pin_qual
  import sdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin,
  input  logic              shut,
  input  logic              enter,
  input  logic [MODE_W-1:0] pmode,
  input  logic [DBC_W-1:0]  dbc,
  output logic              qual
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [DBC_W-1:0]       cnt_q, cnt_d;
  logic                   ref_q, ref_d;
  logic                   pin_s, cond;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d[0] = pin;
    for (int i = 1; i < SYNC_STAGES; i++) sync_d[i] = sync_q[i-1];
  end

  always_comb begin
    unique case (pmode)
      PM_HIGH: cond = pin_s;
      PM_LOW:  cond = !pin_s;
      PM_CHG:  cond = (pin_s != ref_q);
      default: cond = 1'b0;
    endcase
  end

  always_comb begin
    ref_d = enter ? pin_s : ref_q;
    if (shut && cond) cnt_d = (cnt_q >= dbc) ? cnt_q : cnt_q + 1'b1;
    else              cnt_d = '0;
  end

  assign qual = shut && cond && (cnt_q >= dbc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      ref_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
      if (enter) ref_q <= ref_d;
    end
  end
endmodule

// File: rtl/sdc_power.sv
module sdc_power
  import sdc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter,
  input  logic            pin_qual,
  input  logic            tmr_wake,
  input  logic            clk_wake,
  input  logic            tmr_en,
  input  logic            clk_en,
  input  logic            stat_rd,
  output logic            pwr_en,
  output logic [NSRC-1:0] stat
);
  logic            pwr_q, pwr_d;
  logic [NSRC-1:0] stat_q, stat_d, hit;

  always_comb begin
    hit[SRC_PIN] = pin_qual;
    hit[SRC_TMR] = !pwr_q && tmr_en && tmr_wake;
    hit[SRC_CLK] = !pwr_q && clk_en && clk_wake;
    pwr_d = pwr_q;
    if (enter)           pwr_d = 1'b0;
    else if (|hit)       pwr_d = 1'b1;
    stat_d = (stat_rd ? '0 : stat_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b1;
      stat_q <= '0;
    end else begin
      pwr_q  <= pwr_d;
      stat_q <= stat_d;
    end
  end

  assign pwr_en = pwr_q;
  assign stat   = stat_q;
endmodule

// File: rtl/sdc_top.sv
module sdc_top
  import sdc_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wake_pin,
  input  logic              tmr_wake,
  input  logic              clk_wake,
  output logic              pwr_en
);
  mode_cfg_t       cfg;
  logic            shut_req, stat_rd, enter, pin_qual;
  logic [NSRC-1:0] stat;

  assign enter = shut_req && pwr_en;

  sdc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .stat, .bus_rdata, .cfg, .shut_req, .stat_rd
  );

  sdc_pin_qual #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk, .rst_n, .pin(wake_pin), .shut(!pwr_en), .enter,
    .pmode(cfg.pmode), .dbc(cfg.dbc), .qual(pin_qual)
  );

  sdc_power u_pwr (
    .clk, .rst_n, .enter, .pin_qual, .tmr_wake, .clk_wake,
    .tmr_en(cfg.tmr_en), .clk_en(cfg.clk_en), .stat_rd,
    .pwr_en, .stat
  );
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
  import sdc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              tmr_wake,
  input logic              pwr_en,
  input mode_cfg_t         cfg,
  input logic [NSRC-1:0]   stat
);
  logic ctrl_wr, good_key, stat_read, pin_off;
  assign ctrl_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign good_key  = (bus_wdata[31:24] == SHUT_KEY) && bus_wdata[0];
  assign stat_read = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign pin_off   = !(cfg.pmode inside {PM_HIGH, PM_LOW, PM_CHG});

  p_keyed_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && good_key && pwr_en) |=> !pwr_en);

  p_bad_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !good_key && pwr_en) |=> pwr_en);

  p_on_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !stat_read) |=> $stable(stat));

  p_all_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && !cfg.tmr_en && !cfg.clk_en && pin_off) |=> !pwr_en);

  p_timer_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && cfg.tmr_en && tmr_wake) |=> (pwr_en && stat[SRC_TMR]));

  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && pwr_en) |=> (stat == '0));
endmodule

bind sdc_top sdc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tmr_wake(tmr_wake),
  .pwr_en(pwr_en), .cfg(cfg), .stat(stat)
);

// File: tb/tb_sdc_top.sv
`timescale 1ns/1ps
module tb_sdc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        wake_pin, tmr_wake, clk_wake, pwr_en;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  sdc_top dut (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .wake_pin, .tmr_wake, .clk_wake, .pwr_en
  );

  function automatic logic [31:0] exp_mode(input logic [31:0] w);
    return w & 32'h0003_00F7;
  endfunction

  function automatic logic exp_pin(input logic [2:0] m, input logic s, input logic l);
    case (m)
      3'd1: return s || l;
      3'd2: return !s || !l;
      3'd3: return s != l;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    wake_pin = 0; tmr_wake = 0; clk_wake = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    chk("R1 pwr_en", {31'd0, pwr_en}, 32'd1);
    bus_read(4'h4, rd); chk("R1 mode", rd, 0);
    bus_read(4'h8, rd); chk("R1 status", rd, 0);
    // R3 readback
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4, rd); chk("R3 mode readback", rd, exp_mode(32'hFFFF_FFFF));
    bus_read(4'h0, rd); chk("R2 ctrl reads 0", rd, 0);
    // R8 pulses while powered ignored
    tmr_wake = 1; clk_wake = 1; @(negedge clk); tmr_wake = 0; clk_wake = 0;
    @(negedge clk);
    bus_read(4'h8, rd); chk("R8 no status while on", rd, 0);
    // R4 bad key / missing bit
    bus_write(4'h0, 32'hA400_0001);
    chk("R4 bad key", {31'd0, pwr_en}, 32'd1);
    bus_write(4'h0, 32'hA500_0000);
    chk("R4 bit0 clear", {31'd0, pwr_en}, 32'd1);
    // R2 keyed shutdown, all sources disabled
    bus_write(4'h4, 32'h0000_0000);
    bus_write(4'h0, 32'hA500_0001);
    chk("R2 shutdown", {31'd0, pwr_en}, 32'd0);
    wake_pin = 1; tmr_wake = 1; clk_wake = 1;
    repeat (5) @(negedge clk);
    wake_pin = 0; tmr_wake = 0; clk_wake = 0;
    chk("R8 disabled stays off", {31'd0, pwr_en}, 32'd0);
    // R6 debounce: count 3, mode high; short pulse then exact wake edge
    bus_write(4'h4, 32'h0000_0031);
    repeat (3) @(negedge clk);
    wake_pin = 1; repeat (3) @(negedge clk); wake_pin = 0;
    repeat (6) @(negedge clk);
    chk("R6 short pulse no wake", {31'd0, pwr_en}, 32'd0);
    wake_pin = 1;
    repeat (5) @(negedge clk);
    chk("R6 before edge", {31'd0, pwr_en}, 32'd0);
    @(negedge clk);
    chk("R6 wake edge", {31'd0, pwr_en}, 32'd1);
    wake_pin = 0;
    // R9 clear on read
    bus_read(4'h8, rd); chk("R9 pin status", rd, 32'h1);
    bus_read(4'h8, rd); chk("R9 cleared", rd, 0);
    // R7 clock wake
    bus_write(4'h4, 32'h0002_0000);
    bus_write(4'h0, 32'hA500_0001);
    clk_wake = 1; @(negedge clk); clk_wake = 0;
    chk("R7 clock wake", {31'd0, pwr_en}, 32'd1);
    bus_read(4'h8, rd); chk("R7 clock status", rd, 32'h0002_0000);

    // random scenarios (R5, R7, R8)
    for (int it = 0; it < 40; it++) begin
      logic [2:0] pm; logic [3:0] dbc; logic te, ce, s, l, tp, cp, pw;
      logic [31:0] es;
      pm = 3'($urandom); dbc = 4'($urandom);
      te = 1'($urandom); ce = 1'($urandom);
      s = 1'($urandom); l = 1'($urandom);
      tp = 1'($urandom); cp = 1'($urandom);
      do_reset();
      bus_write(4'h4, {14'd0, ce, te, 8'd0, dbc, 1'b0, pm});
      wake_pin = s;
      repeat (4) @(negedge clk);
      bus_write(4'h0, 32'hA5FF_FF01);
      chk("R2 random shutdown", {31'd0, pwr_en}, 32'd0);
      repeat (20) @(negedge clk);
      wake_pin = l;
      repeat (22) @(negedge clk);
      tmr_wake = tp; clk_wake = cp;
      @(negedge clk);
      tmr_wake = 0; clk_wake = 0;
      pw = exp_pin(pm, s, l);
      es = pw ? 32'h1 : {14'd0, cp & ce, tp & te, 16'd0};
      chk("R5/R7 random pwr_en", {31'd0, pwr_en},
          {31'd0, pw | (tp & te) | (cp & ce)});
      bus_read(4'h8, rd); chk("R5/R8 random status", rd, es);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule